// File: doc/BRIEF.md
# Pulse-Count FSK Demodulator

This block turns a hard-limited frequency-shift-keyed receive signal back into binary data by counting its zero crossings. Every transition of the 1-bit input, up or down, launches a pulse of a programmable, fixed length. The pulse rate is therefore twice the tone frequency. The mean level of the pulse train rises with the received frequency.

A first-order recursive low-pass filter extracts that mean. Its time constant is picked from a rate code, so that the smoothing suits the symbol rate in use (1200, 600, 150, 75 or 5 baud). The filtered level is sliced against a programmable threshold. Because the lower tone of each pair is the mark, a level below the threshold gives mark (1) and a level at or above it gives space (0). The threshold can be trimmed to cancel bias distortion, which is the departure from an even split of mark and space time on an alternating pattern.

Top module: `fsk_pulse_demod`

## Requirements
- R1: Each rising and each falling transition of `rx_lim` starts a pulse on `pulse_out`. With no pulse running, `pulse_out` goes high on the third rising clock edge after the input changes.
- R2: A pulse lasts exactly `pulse_len` clock cycles. When `pulse_len` is 0, no pulse is produced.
- R3: A transition that arrives while a pulse is running restarts the full length. Transitions spaced closer than `pulse_len` therefore hold `pulse_out` high continuously.
- R4: `filt_val` is 0 after reset and never rises while `pulse_out` is low. With a steady tone its average settles, to within 2% of full scale, at (2^THR_W-1) times the fraction of time that `pulse_out` is high.
- R5: `rx_data` is 1 when `filt_val` was below `slice_thr` on the previous cycle, and 0 otherwise, including the case where the two are equal.
- R6: With a suitable threshold, a low tone (longer half period) decodes as a steady 1 and a high tone decodes as a steady 0.
- R7: `rate_sel` picks the filter time constant: 0 = 1200 baud (shift 6), 1 = 600 (7), 2 = 150 (9), 3 = 75 (10), 4 = 5 baud (13). Codes 5 to 7 act as code 0.
- R8: During and right after reset, `pulse_out` is 0, `filt_val` is 0 and `rx_data` is 1.
- R9: Moving `slice_thr` across the settled level of a tone flips the decision for that tone, so the slicing point can be trimmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_lim | input | 1 | Hard-limited receive signal, asynchronous to the clock |
| pulse_len | input | PW_W | Pulse length in clock cycles |
| slice_thr | input | THR_W | Decision threshold for the filtered level |
| rate_sel | input | 3 | Symbol rate code that selects the filter time constant |
| pulse_out | output | 1 | Fixed-length edge pulse train |
| filt_val | output | THR_W | Low-pass filtered pulse density |
| rx_data | output | 1 | Recovered data, 1 = mark, 0 = space |

## Verification
A wrong pulse counter shows up on `pulse_out` within a few cycles of a single input transition. It appears as a wrong start cycle, a wrong width, or a pulse that ignores a retrigger. A wrong accumulator or shift selection moves the settled value of `filt_val` away from the duty-cycle product. The error appears within a few time constants, which is a few hundred cycles at the fast rate code, or as a settling speed that does not match the rate code. A wrong comparator shows in `rx_data` one cycle after the threshold is set exactly at a known filter level, such as the zero level after reset.

// File: rtl/fsk_pulse_demod.sv
module fsk_pulse_demod #(
  parameter int PW_W    = 12,
  parameter int THR_W   = 16,
  parameter int FRAC_W  = 16,
  parameter int SH_1200 = 6,
  parameter int SH_600  = 7,
  parameter int SH_150  = 9,
  parameter int SH_75   = 10,
  parameter int SH_5    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_lim,
  input  logic [PW_W-1:0]  pulse_len,
  input  logic [THR_W-1:0] slice_thr,
  input  logic [2:0]       rate_sel,
  output logic             pulse_out,
  output logic [THR_W-1:0] filt_val,
  output logic             rx_data
);
  localparam int ACC_W = THR_W + FRAC_W;

  logic [2:0]       sync_q;
  logic             xing;
  logic [PW_W-1:0]  cnt;
  logic [4:0]       sh;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] target;
  logic signed [ACC_W:0] diff;
  logic signed [ACC_W:0] step;
  logic signed [ACC_W:0] acc_nx;

  assign xing = sync_q[1] ^ sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], rx_lim};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (xing && pulse_len != 0) cnt <= pulse_len;
    else if (cnt != 0)               cnt <= cnt - 1'b1;
  end

  assign pulse_out = (cnt != 0);

  always_comb begin
    case (rate_sel)
      3'd1:    sh = 5'(SH_600);
      3'd2:    sh = 5'(SH_150);
      3'd3:    sh = 5'(SH_75);
      3'd4:    sh = 5'(SH_5);
      default: sh = 5'(SH_1200);
    endcase
  end

  assign target = pulse_out ? {{THR_W{1'b1}}, {FRAC_W{1'b0}}} : '0;
  assign diff   = $signed({1'b0, target}) - $signed({1'b0, acc});
  assign step   = diff >>> sh;
  assign acc_nx = $signed({1'b0, acc}) + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nx[ACC_W-1:0];
  end

  assign filt_val = acc[ACC_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_data <= 1'b1;
    else        rx_data <= (filt_val < slice_thr);
  end

  AST_EDGE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xing && pulse_len != 0) |=> pulse_out); // R1
  AST_ZERO_LEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_len == 0 && !pulse_out) |=> !pulse_out); // R2
  AST_FILT_NO_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_out |=> filt_val <= $past(filt_val)); // R4
  AST_FILT_NO_FALL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> filt_val >= $past(filt_val)); // R4
  AST_SLICE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_val >= slice_thr) |=> !rx_data); // R5
  AST_SLICE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_val < slice_thr) |=> rx_data); // R5
endmodule

// File: tb/sim_fsk_pulse_demod.sv
module sim_fsk_pulse_demod;
  localparam int CLK_PERIOD = 10;
  localparam int FS = 65535;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_lim = 0;
  logic [11:0] pulse_len = 12'd2;
  logic [15:0] slice_thr = 16'd24576;
  logic [2:0]  rate_sel = 3'd0;
  logic        pulse_out;
  logic [15:0] filt_val;
  logic        rx_data;

  int checks = 0;
  int errors = 0;

  fsk_pulse_demod u0 (
    .clk(clk), .rst_n(rst_n), .rx_lim(rx_lim), .pulse_len(pulse_len),
    .slice_thr(slice_thr), .rate_sel(rate_sel), .pulse_out(pulse_out),
    .filt_val(filt_val), .rx_data(rx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    rx_lim = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_tone(input int h, input int n, output longint sum, output int ones);
    sum = 0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % h == 0) rx_lim = ~rx_lim;
      sum += filt_val;
      if (rx_data) ones++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(pulse_out == 0, "R8 pulse in reset", pulse_out, 0);
    chk(filt_val == 0, "R8 filt in reset", filt_val, 0);
    chk(rx_data == 1, "R8 rx_data in reset", rx_data, 1);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(filt_val == 0 && pulse_out == 0 && rx_data == 1, "R8 after reset",
        {filt_val, pulse_out, rx_data}, 1);
  endtask

  task automatic t_single_pulse(input bit dir);
    int hi;
    hi = 0;
    pulse_len = 12'd5;
    @(negedge clk);
    rx_lim = dir;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (pulse_out) hi++;
      if (k == 2) chk(pulse_out == 0, "R1 not yet at cycle 2", pulse_out, 0);
      if (k == 3) chk(pulse_out == 1, "R1 pulse at cycle 3", pulse_out, 1);
      if (k == 7) chk(pulse_out == 1, "R2 still high at cycle 7", pulse_out, 1);
      if (k == 8) chk(pulse_out == 0, "R2 low at cycle 8", pulse_out, 0);
    end
    chk(hi == 5, "R2 pulse width", hi, 5);
  endtask

  task automatic t_zero_len();
    int hi;
    hi = 0;
    do_reset();
    pulse_len = 12'd0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k % 3 == 0) rx_lim = ~rx_lim;
      if (pulse_out) hi++;
    end
    chk(hi == 0, "R2 zero length gives no pulse", hi, 0);
    chk(filt_val == 0, "R4 no pulses keeps filter at 0", filt_val, 0);
  endtask

  task automatic t_thresh_equal();
    slice_thr = 16'd0;
    repeat (2) @(negedge clk);
    chk(rx_data == 0, "R5 equal level is space", rx_data, 0);
    slice_thr = 16'd1;
    repeat (2) @(negedge clk);
    chk(rx_data == 1, "R5 below threshold is mark", rx_data, 1);
  endtask

  task automatic t_retrigger();
    int lows;
    longint s;
    int o;
    do_reset();
    pulse_len = 12'd4;
    run_tone(2, 8, s, o);
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k % 2 == 0) rx_lim = ~rx_lim;
      if (!pulse_out) lows++;
    end
    chk(lows == 0, "R3 retrigger holds pulse high", lows, 0);
  endtask

  task automatic t_rate(input logic [2:0] code, input bit fast);
    longint s;
    int o;
    do_reset();
    rate_sel = code;
    pulse_len = 12'd4;
    run_tone(2, 128, s, o);
    if (fast) chk(filt_val > 50000, "R7 fast rate settles", filt_val, 50000);
    else      chk(filt_val < 3000, "R7 slow rate still low", filt_val, 3000);
    rate_sel = 3'd0;
  endtask

  task automatic t_tones();
    longint s;
    int o;
    longint avg;
    do_reset();
    pulse_len = 12'd2;
    slice_thr = 16'd24576;
    run_tone(8, 600, s, o);
    run_tone(8, 400, s, o);
    avg = s / 400;
    chk(avg > FS/4 - 1311 && avg < FS/4 + 1311, "R4 mark tone level", avg, FS/4);
    chk(o == 400, "R6 low tone decodes as mark", o, 400);
    slice_thr = 16'd12000;
    run_tone(8, 40, s, o);
    chk(o == 0, "R9 lowered threshold turns mark tone to space", o, 0);
    slice_thr = 16'd21000;
    run_tone(8, 40, s, o);
    chk(o == 40, "R9 raised threshold restores mark", o, 40);
    slice_thr = 16'd24576;
    run_tone(4, 600, s, o);
    run_tone(4, 400, s, o);
    avg = s / 400;
    chk(avg > FS/2 - 1311 && avg < FS/2 + 1311, "R4 space tone level", avg, FS/2);
    chk(o == 0, "R6 high tone decodes as space", o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
      begin
        t_reset();
        t_single_pulse(1'b1);
        t_single_pulse(1'b0);
        t_zero_len();
        t_thresh_equal();
        t_retrigger();
        t_rate(3'd0, 1'b1);
        t_rate(3'd4, 1'b0);
        t_rate(3'd7, 1'b1);
        t_tones();
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule